// File: doc/BRIEF.md
# Trigger-Counter Slow-Control Register Bank

This block is the register file behind a byte-wide slow-control port of a front-end timing readout chip. It serves read-only identification values that come straight from strap inputs, a fixed revision byte, and a sticky error-status byte that a slow-control write clears. It also keeps counters for received triggers, rejected triggers, completed readout sequences and detected single-event upsets. Each counter has its own clearing rule. The physical bus layer, the DLL, the derandomizing buffer and the upset detector sit outside the block and reach it only as single-cycle event pulses or levels.

Software writes an operating mode into a shadow register. The mode driven to the rest of the chip changes only when the trigger system issues its reset pulse, so a mode change cannot land in the middle of a trigger sequence. A write to the DLL control address issues a one-cycle DLL reset command. Reads are combinational from the current address. Writes take effect on the rising clock edge while the write strobe is high.

Top module: `trig_regbank`

## Requirements
- R1: Reading address 0x0 returns strap ID bits [7:0]. Reading 0x1 returns the upper strap ID bits (bits [11:8] with the default width) in the low nibble, with zeros above. Reading 0x2 returns the 7-bit strap bus address with bit 7 at zero. All three follow the strap inputs directly.
- R2: Reading address 0x3 returns the REVISION parameter.
- R3: Reading address 0x4 returns the status byte. Bit 0 is self-test failure, bit 1 is DLL lock lost, bit 2 is buffer overflow and bit 3 is an upset detected in the control logic. Bits 7:4 read as zero. A bit sets on the edge after its input is high, and it stays set until cleared.
- R4: Any write to address 0x4 clears all status bits. If a flag input is high in the same cycle as the clearing write, that flag is set afterwards.
- R5: The received-trigger, rejected-trigger and completed-readout counters each advance by one on every cycle their input is high. Reads of 0x5, 0x6 and 0x7 return the low 8 bits of each CNT_W-bit counter, and each counter wraps at 2^CNT_W.
- R6: A write to 0x5 clears the received counter, and a write to 0x6 clears the rejected counter. A clear wins over an increment in the same cycle.
- R7: Only evtIdReset clears the completed-readout counter, and it wins over readoutDone in the same cycle. Writes to 0x7 have no effect.
- R8: Suppose each received trigger is either rejected in the same cycle or later followed by exactly one readoutDone, and no counter has been cleared on its own. Once no readout is pending, read(0x5) = (read(0x7) + read(0x6)) mod 256.
- R9: The 8-bit upset counter at 0x8 advances on each cycle that upsetDetect is high and wraps at 256. A write to 0x8 clears it, and the clear wins over a same-cycle increment.
- R10: A write to 0x9 loads the shadow mode, and reading 0x9 returns the shadow. modeActive takes the shadow value held before the edge, one cycle after sysReset is high. At all other times it is unchanged.
- R11: A write to 0xA with data bit 0 at 1 drives dllResetPulse high for exactly the following cycle. A write with bit 0 at 0 gives no pulse. Reading 0xA returns 0x00.
- R12: Writes to addresses 0x0 to 0x3 are ignored. Reads of 0xB to 0xF return 0x00.
- R13: While rstN is low, all counters, status bits, shadow mode and active mode are zero and dllResetPulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe, one write per high cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| strapId | input | ID_W | Chip identification straps |
| strapBusId | input | 7 | Bus address straps |
| selfTestFail | input | 1 | Memory self-test failure flag |
| dllLockLost | input | 1 | DLL lock lost flag |
| bufOverflow | input | 1 | Derandomizing buffer overflow flag |
| upsetDetect | input | 1 | Upset detected in control logic, one pulse per upset |
| trigIn | input | 1 | Trigger received pulse |
| trigReject | input | 1 | Trigger rejected pulse |
| readoutDone | input | 1 | Readout sequence completed pulse |
| evtIdReset | input | 1 | Clears the completed-readout counter |
| sysReset | input | 1 | Trigger-system reset, applies shadow mode |
| modeActive | output | 8 | Active operating mode |
| dllResetPulse | output | 1 | One-cycle DLL reset command |

## Verification
The bench builds the block with CNT_W = 9 and REVISION = 0x5A, keeping ID_W at 12. With a 9-bit internal counter, a run of 520 triggers passes both the wrap of the 8-bit read view and the wrap of the counter itself, which separates the view from the true width. A revision value that is not the default catches a hard-wired constant. Mixed sequences of rejected and completed triggers exercise the counter identity R8, and same-cycle collisions exercise each clear-versus-event priority.

// File: rtl/trig_regbank_pkg.sv
package trig_regbank_pkg;

  localparam int REG_ADDR_W = 4;
  localparam int BYTE_W     = 8;
  localparam int STATUS_W   = 4;

  localparam int ST_SELFTEST = 0;
  localparam int ST_DLLLOCK  = 1;
  localparam int ST_OVERFLOW = 2;
  localparam int ST_UPSET    = 3;

  localparam logic [REG_ADDR_W-1:0] A_ID_LO  = 4'h0;
  localparam logic [REG_ADDR_W-1:0] A_ID_HI  = 4'h1;
  localparam logic [REG_ADDR_W-1:0] A_BUS_ID = 4'h2;
  localparam logic [REG_ADDR_W-1:0] A_REV    = 4'h3;
  localparam logic [REG_ADDR_W-1:0] A_STATUS = 4'h4;
  localparam logic [REG_ADDR_W-1:0] A_RECV   = 4'h5;
  localparam logic [REG_ADDR_W-1:0] A_REJ    = 4'h6;
  localparam logic [REG_ADDR_W-1:0] A_EVT    = 4'h7;
  localparam logic [REG_ADDR_W-1:0] A_UPSET  = 4'h8;
  localparam logic [REG_ADDR_W-1:0] A_MODE   = 4'h9;
  localparam logic [REG_ADDR_W-1:0] A_DLL    = 4'hA;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_ID_LO,
    SEL_ID_HI,
    SEL_BUS_ID,
    SEL_REV,
    SEL_STATUS,
    SEL_RECV,
    SEL_REJ,
    SEL_EVT,
    SEL_UPSET,
    SEL_MODE
  } rdSel_e;

  typedef struct packed {
    logic clrStatus;
    logic clrRecv;
    logic clrRej;
    logic clrUpset;
    logic loadShadow;
    logic dllCmd;
  } ctlStrobes_t;

endpackage

// File: rtl/trig_regbank_cnt.sv
module trig_regbank_cnt #(
  parameter int W      = 16,
  parameter int VIEW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              inc,
  output logic [VIEW_W-1:0] view
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cntQ <= '0;
    else if (clr)   cntQ <= '0;
    else if (inc)   cntQ <= cntQ + ONE;
  end

  assign view = cntQ[VIEW_W-1:0];
endmodule

// File: rtl/trig_regbank_ctl.sv
module trig_regbank_ctl
  import trig_regbank_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrEn,
  input  logic                  wrBit0,
  output ctlStrobes_t           strobes,
  output rdSel_e                rdSel
);
  always_comb begin
    strobes            = '0;
    strobes.clrStatus  = wrEn && (regAddr == A_STATUS);
    strobes.clrRecv    = wrEn && (regAddr == A_RECV);
    strobes.clrRej     = wrEn && (regAddr == A_REJ);
    strobes.clrUpset   = wrEn && (regAddr == A_UPSET);
    strobes.loadShadow = wrEn && (regAddr == A_MODE);
    strobes.dllCmd     = wrEn && (regAddr == A_DLL) && wrBit0;
  end

  always_comb begin
    case (regAddr)
      A_ID_LO:  rdSel = SEL_ID_LO;
      A_ID_HI:  rdSel = SEL_ID_HI;
      A_BUS_ID: rdSel = SEL_BUS_ID;
      A_REV:    rdSel = SEL_REV;
      A_STATUS: rdSel = SEL_STATUS;
      A_RECV:   rdSel = SEL_RECV;
      A_REJ:    rdSel = SEL_REJ;
      A_EVT:    rdSel = SEL_EVT;
      A_UPSET:  rdSel = SEL_UPSET;
      A_MODE:   rdSel = SEL_MODE;
      default:  rdSel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/trig_regbank_dp.sv
module trig_regbank_dp
  import trig_regbank_pkg::*;
#(
  parameter int          ID_W     = 12,
  parameter int          BUS_ID_W = 7,
  parameter int          CNT_W    = 16,
  parameter int          UPSET_W  = 8,
  parameter logic [7:0]  REVISION = 8'h0B
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  rdSel_e               rdSel,
  input  logic [BYTE_W-1:0]    wrData,
  input  logic [ID_W-1:0]      strapId,
  input  logic [BUS_ID_W-1:0]  strapBusId,
  input  logic [STATUS_W-1:0]  statusEvt,
  input  logic                 trigIn,
  input  logic                 trigReject,
  input  logic                 readoutDone,
  input  logic                 evtIdReset,
  input  logic                 upsetDetect,
  input  logic                 sysReset,
  output logic [BYTE_W-1:0]    rdData,
  output logic [BYTE_W-1:0]    modeActive,
  output logic [BYTE_W-1:0]    modeShadow,
  output logic [STATUS_W-1:0]  statusQ,
  output logic                 dllResetPulse
);
  localparam int ID_HI_W  = ID_W - BYTE_W;
  localparam int ID_PAD_W = BYTE_W - ID_HI_W;
  localparam int BUS_PAD  = BYTE_W - BUS_ID_W;
  localparam int ST_PAD   = BYTE_W - STATUS_W;

  logic [BYTE_W-1:0] recvView, rejView, evtView, upsetView;

  // sticky flags, one per status bit
  for (genvar i = 0; i < STATUS_W; i++) begin : gStatus
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= (statusQ[i] & ~strobes.clrStatus) | statusEvt[i];
    end
  end

  trig_regbank_cnt #(.W(CNT_W), .VIEW_W(BYTE_W)) uRecvCnt (
    .clk(clk), .rstN(rstN), .clr(strobes.clrRecv), .inc(trigIn), .view(recvView));

  trig_regbank_cnt #(.W(CNT_W), .VIEW_W(BYTE_W)) uRejCnt (
    .clk(clk), .rstN(rstN), .clr(strobes.clrRej), .inc(trigReject), .view(rejView));

  trig_regbank_cnt #(.W(CNT_W), .VIEW_W(BYTE_W)) uEvtCnt (
    .clk(clk), .rstN(rstN), .clr(evtIdReset), .inc(readoutDone), .view(evtView));

  trig_regbank_cnt #(.W(UPSET_W), .VIEW_W(BYTE_W)) uUpsetCnt (
    .clk(clk), .rstN(rstN), .clr(strobes.clrUpset), .inc(upsetDetect), .view(upsetView));

  // shadowed mode, applied only on trigger-system reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeShadow <= '0;
      modeActive <= '0;
    end else begin
      if (strobes.loadShadow) modeShadow <= wrData;
      if (sysReset)           modeActive <= modeShadow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dllResetPulse <= 1'b0;
    else       dllResetPulse <= strobes.dllCmd;
  end

  always_comb begin
    case (rdSel)
      SEL_ID_LO:  rdData = strapId[BYTE_W-1:0];
      SEL_ID_HI:  rdData = {{ID_PAD_W{1'b0}}, strapId[ID_W-1:BYTE_W]};
      SEL_BUS_ID: rdData = {{BUS_PAD{1'b0}}, strapBusId};
      SEL_REV:    rdData = REVISION;
      SEL_STATUS: rdData = {{ST_PAD{1'b0}}, statusQ};
      SEL_RECV:   rdData = recvView;
      SEL_REJ:    rdData = rejView;
      SEL_EVT:    rdData = evtView;
      SEL_UPSET:  rdData = upsetView;
      SEL_MODE:   rdData = modeShadow;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/trig_regbank.sv
module trig_regbank
  import trig_regbank_pkg::*;
#(
  parameter int         ID_W     = 12,
  parameter int         CNT_W    = 16,
  parameter logic [7:0] REVISION = 8'h0B
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrEn,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  input  logic [ID_W-1:0]       strapId,
  input  logic [6:0]            strapBusId,
  input  logic                  selfTestFail,
  input  logic                  dllLockLost,
  input  logic                  bufOverflow,
  input  logic                  upsetDetect,
  input  logic                  trigIn,
  input  logic                  trigReject,
  input  logic                  readoutDone,
  input  logic                  evtIdReset,
  input  logic                  sysReset,
  output logic [7:0]            modeActive,
  output logic                  dllResetPulse
);
  ctlStrobes_t         strobes;
  rdSel_e              rdSel;
  logic [STATUS_W-1:0] statusEvt;
  logic [STATUS_W-1:0] statusQ;
  logic [7:0]          modeShadow;

  always_comb begin
    statusEvt              = '0;
    statusEvt[ST_SELFTEST] = selfTestFail;
    statusEvt[ST_DLLLOCK]  = dllLockLost;
    statusEvt[ST_OVERFLOW] = bufOverflow;
    statusEvt[ST_UPSET]    = upsetDetect;
  end

  trig_regbank_ctl uCtl (
    .regAddr(regAddr), .wrEn(wrEn), .wrBit0(wrData[0]),
    .strobes(strobes), .rdSel(rdSel));

  trig_regbank_dp #(
    .ID_W(ID_W), .BUS_ID_W(7), .CNT_W(CNT_W), .UPSET_W(8), .REVISION(REVISION)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel), .wrData(wrData),
    .strapId(strapId), .strapBusId(strapBusId), .statusEvt(statusEvt),
    .trigIn(trigIn), .trigReject(trigReject), .readoutDone(readoutDone),
    .evtIdReset(evtIdReset), .upsetDetect(upsetDetect), .sysReset(sysReset),
    .rdData(rdData), .modeActive(modeActive), .modeShadow(modeShadow),
    .statusQ(statusQ), .dllResetPulse(dllResetPulse));
endmodule

// File: rtl/trig_regbank_chk.sv
module trig_regbank_chk #(
  parameter logic [7:0] REVISION = 8'h0B
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] regAddr,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       selfTestFail,
  input logic       dllLockLost,
  input logic       bufOverflow,
  input logic       upsetDetect,
  input logic       sysReset,
  input logic [7:0] modeActive,
  input logic       dllResetPulse,
  input logic [3:0] statusQ,
  input logic [7:0] modeShadow
);
  logic       clrWr;
  logic [3:0] flagIn;
  assign clrWr  = wrEn && (regAddr == 4'h4);
  assign flagIn = {upsetDetect, bufOverflow, dllLockLost, selfTestFail};

  for (genvar i = 0; i < 4; i++) begin : gFlag
    assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !clrWr) |=> statusQ[i])
      else $error("status bit lost without clear");
    assert_status_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      flagIn[i] |=> statusQ[i])
      else $error("status bit not set by event");
  end

  assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && flagIn == 4'b0) |=> (statusQ == 4'b0))
    else $error("status not cleared");

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !sysReset |=> $stable(modeActive))
    else $error("active mode moved without system reset");

  assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> (modeActive == $past(modeShadow)))
    else $error("active mode not loaded from shadow");

  assert_dll_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    dllResetPulse |-> $past(wrEn && regAddr == 4'hA && wrData[0]))
    else $error("DLL pulse without command");

  assert_rev_const_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 4'h3) |-> (rdData == REVISION))
    else $error("revision read wrong");

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= 4'hB) |-> (rdData == 8'h00))
    else $error("unmapped read not zero");
endmodule

bind trig_regbank trig_regbank_chk #(.REVISION(REVISION)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .selfTestFail(selfTestFail), .dllLockLost(dllLockLost),
  .bufOverflow(bufOverflow), .upsetDetect(upsetDetect), .sysReset(sysReset),
  .modeActive(modeActive), .dllResetPulse(dllResetPulse), .statusQ(statusQ),
  .modeShadow(modeShadow));

// File: tb/trig_regbank_bench.sv
`timescale 1ns/1ps
module trig_regbank_bench;
  localparam int         ID_W  = 12;
  localparam int         CNT_W = 9;
  localparam logic [7:0] REV   = 8'h5A;
  localparam int         CMASK = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [ID_W-1:0] strapId = 12'hABC;
  logic [6:0] strapBusId = 7'h55;
  logic selfTestFail = 0, dllLockLost = 0, bufOverflow = 0, upsetDetect = 0;
  logic trigIn = 0, trigReject = 0, readoutDone = 0, evtIdReset = 0, sysReset = 0;
  logic [7:0] modeActive;
  logic dllResetPulse;

  always #2 clk = ~clk;

  trig_regbank #(.ID_W(ID_W), .CNT_W(CNT_W), .REVISION(REV)) u_trig_regbank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .strapId(strapId), .strapBusId(strapBusId),
    .selfTestFail(selfTestFail), .dllLockLost(dllLockLost), .bufOverflow(bufOverflow),
    .upsetDetect(upsetDetect), .trigIn(trigIn), .trigReject(trigReject),
    .readoutDone(readoutDone), .evtIdReset(evtIdReset), .sysReset(sysReset),
    .modeActive(modeActive), .dllResetPulse(dllResetPulse));

  int total = 0, failed = 0;
  bit done = 0;
  int mStatus, mRecv, mRej, mEvt, mUpset, mShadow, mActive, mPulse;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int modelRead(int a);
    case (a)
      0: return int'(strapId) & 255;
      1: return int'(strapId) >> 8;
      2: return int'(strapBusId);
      3: return int'(REV);
      4: return mStatus;
      5: return mRecv & 255;
      6: return mRej & 255;
      7: return mEvt & 255;
      8: return mUpset;
      9: return mShadow;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(int a);
    case (a)
      0, 1, 2: return "R1";
      3: return "R2";
      4: return "R3";
      5, 6, 7: return "R5";
      8: return "R9";
      9: return "R10";
      10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic modelReset();
    mStatus = 0; mRecv = 0; mRej = 0; mEvt = 0;
    mUpset = 0; mShadow = 0; mActive = 0; mPulse = 0;
  endtask

  // compare read, clock once, advance model, compare registered outputs
  task automatic doStep();
    bit w4, w5, w6, w8, w9;
    #1 check(tagOf(int'(regAddr)), int'(rdData), modelRead(int'(regAddr)));
    @(posedge clk);
    w4 = wrEn && regAddr == 4; w5 = wrEn && regAddr == 5; w6 = wrEn && regAddr == 6;
    w8 = wrEn && regAddr == 8; w9 = wrEn && regAddr == 9;
    if (w4) mStatus = 0;
    mStatus = mStatus | (selfTestFail ? 1 : 0) | (dllLockLost ? 2 : 0)
                      | (bufOverflow ? 4 : 0) | (upsetDetect ? 8 : 0);
    if (w5) mRecv = 0; else if (trigIn) mRecv = (mRecv + 1) & CMASK;
    if (w6) mRej = 0; else if (trigReject) mRej = (mRej + 1) & CMASK;
    if (evtIdReset) mEvt = 0; else if (readoutDone) mEvt = (mEvt + 1) & CMASK;
    if (w8) mUpset = 0; else if (upsetDetect) mUpset = (mUpset + 1) & 255;
    if (sysReset) mActive = mShadow;
    if (w9) mShadow = int'(wrData);
    mPulse = (wrEn && regAddr == 10 && wrData[0]) ? 1 : 0;
    #1;
    check("R10", int'(modeActive), mActive);
    check("R11", int'(dllResetPulse), mPulse);
  endtask

  task automatic rd(int a, int exp, string tag);
    regAddr = 4'(a); wrEn = 0;
    #1 check(tag, int'(rdData), exp);
    doStep();
  endtask

  task automatic wr(int a, int d);
    regAddr = 4'(a); wrData = 8'(d); wrEn = 1;
    doStep();
    wrEn = 0;
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R13: reset values seen during reset
    check("R13", int'(modeActive), 0);
    check("R13", int'(dllResetPulse), 0);
    rstN = 1;
    // reset state of every address
    rd(0, 8'hBC, "R1"); rd(1, 8'h0A, "R1"); rd(2, 8'h55, "R1"); rd(3, 8'h5A, "R2");
    for (int a = 4; a < 16; a++) rd(a, 0, "R13");
    // straps followed live
    strapId = 12'h3E7; strapBusId = 7'h2A;
    rd(0, 8'hE7, "R1"); rd(1, 8'h03, "R1"); rd(2, 8'h2A, "R1");
    // writes to read-only addresses ignored
    for (int a = 0; a < 4; a++) wr(a, 8'hFF);
    wr(7, 8'hFF);
    rd(0, 8'hE7, "R12"); rd(1, 8'h03, "R12"); rd(2, 8'h2A, "R12");
    rd(3, 8'h5A, "R12"); rd(7, 0, "R7");
    for (int a = 11; a < 16; a++) rd(a, 0, "R12");
    // status flags
    selfTestFail = 1; doStep(); selfTestFail = 0;
    rd(4, 8'h01, "R3"); rd(4, 8'h01, "R3");
    dllLockLost = 1; doStep(); dllLockLost = 0;
    rd(4, 8'h03, "R3");
    wr(4, 8'h00);
    rd(4, 8'h00, "R4");
    bufOverflow = 1; wr(4, 8'hFF); bufOverflow = 0;
    rd(4, 8'h04, "R4");
    upsetDetect = 1; doStep(); upsetDetect = 0;
    rd(4, 8'h0C, "R3"); rd(8, 8'h01, "R9");
    wr(4, 0); rd(4, 0, "R4");
    // counters
    trigIn = 1; repeat (5) doStep(); trigIn = 0;
    trigReject = 1; repeat (3) doStep(); trigReject = 0;
    readoutDone = 1; repeat (5) doStep(); readoutDone = 0;
    rd(5, 5, "R5"); rd(6, 3, "R5"); rd(7, 5, "R5");
    // R8: identity from a common zero point
    wr(5, 0); wr(6, 0);
    evtIdReset = 1; doStep(); evtIdReset = 0;
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) begin
        trigIn = 1; trigReject = 1; doStep(); trigIn = 0; trigReject = 0;
      end else begin
        trigIn = 1; doStep(); trigIn = 0;
        readoutDone = 1; doStep(); readoutDone = 0;
      end
    end
    rd(5, 8'h28, "R8"); rd(6, 8'h0E, "R8"); rd(7, 8'h1A, "R8");
    check("R8", 8'h28, (8'h1A + 8'h0E) & 255);
    // R6: clear wins over increment
    trigIn = 1; wr(5, 0); trigIn = 0; rd(5, 0, "R6");
    trigReject = 1; wr(6, 0); trigReject = 0; rd(6, 0, "R6");
    rd(7, 8'h1A, "R6");
    // R7: external reset wins over completion
    readoutDone = 1; evtIdReset = 1; doStep(); readoutDone = 0; evtIdReset = 0;
    rd(7, 0, "R7");
    // R5: wrap of view and of counter
    trigIn = 1; repeat (300) doStep(); trigIn = 0;
    rd(5, 8'h2C, "R5");
    trigIn = 1; repeat (220) doStep(); trigIn = 0;
    rd(5, 8'h08, "R5");
    // R9: upset counter
    wr(8, 0); rd(8, 0, "R9");
    upsetDetect = 1; repeat (260) doStep(); upsetDetect = 0;
    rd(8, 8'h04, "R9");
    upsetDetect = 1; wr(8, 0); upsetDetect = 0;
    rd(8, 0, "R9");
    // R10: shadowed mode
    wr(9, 8'h2C);
    rd(9, 8'h2C, "R10");
    check("R10", int'(modeActive), 0);
    sysReset = 1; doStep(); sysReset = 0;
    check("R10", int'(modeActive), 8'h2C);
    sysReset = 1; wr(9, 8'h11); sysReset = 0;
    check("R10", int'(modeActive), 8'h2C);
    rd(9, 8'h11, "R10");
    check("R10", int'(modeActive), 8'h2C);
    sysReset = 1; doStep(); sysReset = 0;
    check("R10", int'(modeActive), 8'h11);
    // R11: DLL command
    wr(10, 8'h01);
    check("R11", int'(dllResetPulse), 1);
    doStep();
    check("R11", int'(dllResetPulse), 0);
    wr(10, 8'hFE);
    check("R11", int'(dllResetPulse), 0);
    rd(10, 0, "R11");
    // R13: reset mid-run
    rstN = 0; #1; modelReset();
    check("R13", int'(modeActive), 0);
    regAddr = 4; #1 check("R13", int'(rdData), 0);
    @(posedge clk); #1 rstN = 1;
    rd(5, 0, "R13"); rd(9, 0, "R13"); rd(8, 0, "R13");
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule